// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Core

This block holds the control and status registers of an Ethernet MAC and is reached through a plain 32-bit register bus. Writes are single-cycle strobes and reads are combinational. The command register carries the transmit and receive enables, the framing options and a soft reset that clears itself. Its readback shows the soft reset as busy while the reset sequence runs.

The receive and transmit datapaths are modelled by a few inputs. A receive frame starts with a start strobe and finishes with an end strobe that carries the frame length. The transmit side reports a busy level and a FIFO-empty level.

Software stops reception gracefully with a stop request. It then polls a sticky receive-idle event. That event appears only once any frame already under way has finished. After that, software can drop the enables. The block also keeps the maximum frame length, checks received lengths against it, and holds the link-mode and pause-quanta settings for the rest of the MAC.

Top module: `mac_ctl_core`

## Requirements
- R1: After hardware reset the registers read as follows: command at offset 0x008 reads 0, maximum length at 0x014 reads 1536, pause quanta at 0x054 reads 0xF000, link mode at 0x300 reads 0, and events at 0x040 read 0.
- R2: The writable command bits are bit 0 (transmit enable), bit 1 (receive enable), bit 4 (promiscuous), bit 6 (CRC append), bit 11 (transmit padding), bit 17 (length check disabled) and bit 29 (receive stop). Unlisted bits read 0. Bits 0 and 1 drive `macTxEn` and `macRxEn`, and bits 4, 6 and 11 drive `cfgPromisc`, `cfgCrcAppend` and `cfgTxPad`.
- R3: Writing 1 to command bit 12 starts a soft reset. Bit 12 and `softResetBusy` read 1 for exactly 16 cycles, during which both enables are low and all register writes are ignored. When the reset ends, command, maximum length, pause quanta and events return to their reset values, and link mode keeps its value.
- R4: A receive frame is accepted only while it is enabled and no stop is requested. A frame already active when the stop is requested runs to its end strobe. A start strobe arriving while the stop is held is ignored.
- R5: Event bit 6 (receive idle) becomes 1 one cycle after a stop is requested with no frame active.
- R6: Event bit 5 (transmit idle) becomes 1 one cycle after `txBusy` is low while `txFifoEmpty` is high.
- R7: Event bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set condition that is present in the same cycle wins over the clear.
- R8: A maximum length write is stored only when the value lies between 64 and 32736 inclusive. Any other value is ignored.
- R9: When command bit 17 is 0, a frame whose length is strictly greater than the maximum length raises `rxOversize` for exactly one cycle, starting the cycle after the end strobe. No pulse is raised when the length equals the limit, or when bit 17 is 1.
- R10: The link-mode register keeps bits 15:12, 6 and 2:0 (mask 0xF047), reads all other bits as 0, and drives `cfgLinkMode`.
- R11: The pause-quanta register stores the low 16 bits written and drives `cfgPauseQuanta`.
- R12: A start strobe while receive is disabled does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| rxFrameStart | input | 1 | A receive frame begins |
| rxFrameEnd | input | 1 | The active receive frame ends |
| rxFrameLen | input | 16 | Length of the frame ending with `rxFrameEnd` |
| txBusy | input | 1 | A transmit frame is in flight |
| txFifoEmpty | input | 1 | Transmit FIFO holds no data |
| macTxEn | output | 1 | Effective transmit enable |
| macRxEn | output | 1 | Effective receive enable |
| rxFrameActive | output | 1 | An accepted receive frame is in progress |
| rxOversize | output | 1 | One-cycle oversize error flag |
| softResetBusy | output | 1 | Soft reset sequence running |
| cfgPromisc | output | 1 | Promiscuous mode |
| cfgCrcAppend | output | 1 | CRC append on transmit |
| cfgTxPad | output | 1 | Short frame padding on transmit |
| cfgPauseQuanta | output | 16 | Pause quanta setting |
| cfgLinkMode | output | 16 | Link-mode register contents |

## Verification
The bench builds the block with its default parameters: a 16-cycle soft reset, a 16-bit length field, a range of 64 to 32736 for the maximum length, and a reset maximum of 1536. The short reset window lets the bench count every busy cycle of the sequence directly. Because the length field is 16 bits, a write just outside either end of the range is reachable, as are random values above the top limit. With a programmed limit of 200, random frame lengths fall on both sides of the limit and also hit it exactly.

// File: rtl/mac_ctl_pkg.sv
package mac_ctl_pkg;
  localparam int LEN_W = 16;

  // register byte offsets
  localparam int OFS_CMD    = 'h008;
  localparam int OFS_MAXLEN = 'h014;
  localparam int OFS_EVENT  = 'h040;
  localparam int OFS_PAUSE  = 'h054;
  localparam int OFS_LINK   = 'h300;

  // command register bit positions
  localparam int CMD_TXEN     = 0;
  localparam int CMD_RXEN     = 1;
  localparam int CMD_PROMISC  = 4;
  localparam int CMD_CRC      = 6;
  localparam int CMD_PAD      = 11;
  localparam int CMD_SWR      = 12;
  localparam int CMD_NOLENCHK = 17;
  localparam int CMD_RXSTOP   = 29;
  localparam logic [31:0] CMD_WR_MASK = 32'h2002_0853;

  // event register bit positions
  localparam int EVT_TXIDLE = 5;
  localparam int EVT_RXIDLE = 6;

  localparam logic [15:0] LINK_WR_MASK = 16'hF047;

  // control -> datapath strobes
  typedef struct packed {
    logic             rxEn;
    logic             rxStop;
    logic             lenChk;
    logic [LEN_W-1:0] maxLen;
    logic             flush;
  } ctl2dp_t;

  // datapath -> control conditions
  typedef struct packed {
    logic rxIdle;
    logic txIdle;
  } dp2ctl_t;
endpackage

// File: rtl/mac_ctl_regs.sv
module mac_ctl_regs
  import mac_ctl_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SWR_CYCLES = 16,
  parameter int MAXLEN_RST = 1536,
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 32736,
  parameter int PAUSE_RST  = 'hF000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  dp2ctl_t           dpStat,
  output ctl2dp_t           ctlOut,
  output logic              macTxEn,
  output logic              cfgPromisc,
  output logic              cfgCrcAppend,
  output logic              cfgTxPad,
  output logic [15:0]       cfgPauseQuanta,
  output logic [15:0]       cfgLinkMode,
  output logic              softResetBusy
);
  localparam int CNT_W = $clog2(SWR_CYCLES + 1);
  localparam logic [LEN_W-1:0] MAXLEN_INIT = LEN_W'(MAXLEN_RST);
  localparam logic [15:0]      PAUSE_INIT  = 16'(PAUSE_RST);

  logic [31:0]      cmdReg;
  logic [LEN_W-1:0] maxLenReg;
  logic [15:0]      pauseReg;
  logic [15:0]      linkReg;
  logic             evtRx, evtTx;
  logic [CNT_W-1:0] swrCnt;

  logic swrBusy, swrDone, wrOk;
  logic selCmd, selMax, selEvt, selPause, selLink;
  logic lenInRange;

  assign swrBusy = (swrCnt != '0);
  assign swrDone = (swrCnt == CNT_W'(1));
  assign wrOk    = regWrEn && !swrBusy;

  assign selCmd   = (regAddr == ADDR_W'(OFS_CMD));
  assign selMax   = (regAddr == ADDR_W'(OFS_MAXLEN));
  assign selEvt   = (regAddr == ADDR_W'(OFS_EVENT));
  assign selPause = (regAddr == ADDR_W'(OFS_PAUSE));
  assign selLink  = (regAddr == ADDR_W'(OFS_LINK));

  assign lenInRange = (regWrData >= 32'(MIN_LEN)) && (regWrData <= 32'(MAX_LEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= '0;
      maxLenReg <= MAXLEN_INIT;
      pauseReg  <= PAUSE_INIT;
      linkReg   <= '0;
      evtRx     <= 1'b0;
      evtTx     <= 1'b0;
      swrCnt    <= '0;
    end else begin
      if (swrBusy) swrCnt <= swrCnt - CNT_W'(1);
      if (swrDone) begin
        cmdReg    <= '0;
        maxLenReg <= MAXLEN_INIT;
        pauseReg  <= PAUSE_INIT;
        evtRx     <= 1'b0;
        evtTx     <= 1'b0;
      end else begin
        if (wrOk && selCmd) begin
          cmdReg <= regWrData & CMD_WR_MASK;
          if (regWrData[CMD_SWR]) swrCnt <= CNT_W'(SWR_CYCLES);
        end
        if (wrOk && selMax && lenInRange) maxLenReg <= regWrData[LEN_W-1:0];
        if (wrOk && selPause) pauseReg <= regWrData[15:0];
        if (wrOk && selLink) linkReg <= regWrData[15:0] & LINK_WR_MASK;
        // sticky events: set has priority over write-one-to-clear
        evtRx <= dpStat.rxIdle || (evtRx && !(wrOk && selEvt && regWrData[EVT_RXIDLE]));
        evtTx <= dpStat.txIdle || (evtTx && !(wrOk && selEvt && regWrData[EVT_TXIDLE]));
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (selCmd) begin
      regRdData          = cmdReg;
      regRdData[CMD_SWR] = swrBusy;
    end else if (selMax) begin
      regRdData[LEN_W-1:0] = maxLenReg;
    end else if (selEvt) begin
      regRdData[EVT_RXIDLE] = evtRx;
      regRdData[EVT_TXIDLE] = evtTx;
    end else if (selPause) begin
      regRdData[15:0] = pauseReg;
    end else if (selLink) begin
      regRdData[15:0] = linkReg;
    end
  end

  always_comb begin
    ctlOut.rxEn   = cmdReg[CMD_RXEN] && !swrBusy;
    ctlOut.rxStop = cmdReg[CMD_RXSTOP];
    ctlOut.lenChk = !cmdReg[CMD_NOLENCHK];
    ctlOut.maxLen = maxLenReg;
    ctlOut.flush  = swrDone;
  end

  assign macTxEn        = cmdReg[CMD_TXEN] && !swrBusy;
  assign cfgPromisc     = cmdReg[CMD_PROMISC];
  assign cfgCrcAppend   = cmdReg[CMD_CRC];
  assign cfgTxPad       = cmdReg[CMD_PAD];
  assign cfgPauseQuanta = pauseReg;
  assign cfgLinkMode    = linkReg;
  assign softResetBusy  = swrBusy;
endmodule

// File: rtl/mac_ctl_datapath.sv
module mac_ctl_datapath
  import mac_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctl2dp_t          ctlIn,
  input  logic             rxFrameStart,
  input  logic             rxFrameEnd,
  input  logic [LEN_W-1:0] rxFrameLen,
  input  logic             txBusy,
  input  logic             txFifoEmpty,
  output dp2ctl_t          dpStat,
  output logic             rxFrameActive,
  output logic             rxOversize
);
  logic inFrame;
  logic overErr;
  logic startOk;
  logic tooLong;

  assign startOk = rxFrameStart && ctlIn.rxEn && !ctlIn.rxStop;
  assign tooLong = ctlIn.lenChk && (rxFrameLen > ctlIn.maxLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      overErr <= 1'b0;
    end else if (ctlIn.flush) begin
      inFrame <= 1'b0;
      overErr <= 1'b0;
    end else begin
      overErr <= inFrame && rxFrameEnd && tooLong;
      if (inFrame) begin
        if (rxFrameEnd) inFrame <= 1'b0;
      end else if (startOk) begin
        inFrame <= 1'b1;
      end
    end
  end

  assign dpStat.rxIdle = ctlIn.rxStop && !inFrame;
  assign dpStat.txIdle = !txBusy && txFifoEmpty;
  assign rxFrameActive = inFrame;
  assign rxOversize    = overErr;
endmodule

// File: rtl/mac_ctl_core.sv
module mac_ctl_core
  import mac_ctl_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SWR_CYCLES = 16,
  parameter int MAXLEN_RST = 1536,
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 32736,
  parameter int PAUSE_RST  = 'hF000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              rxFrameStart,
  input  logic              rxFrameEnd,
  input  logic [LEN_W-1:0]  rxFrameLen,
  input  logic              txBusy,
  input  logic              txFifoEmpty,
  output logic              macTxEn,
  output logic              macRxEn,
  output logic              rxFrameActive,
  output logic              rxOversize,
  output logic              softResetBusy,
  output logic              cfgPromisc,
  output logic              cfgCrcAppend,
  output logic              cfgTxPad,
  output logic [15:0]       cfgPauseQuanta,
  output logic [15:0]       cfgLinkMode
);
  ctl2dp_t ctlBus;
  dp2ctl_t statBus;

  mac_ctl_regs #(
    .ADDR_W(ADDR_W), .SWR_CYCLES(SWR_CYCLES), .MAXLEN_RST(MAXLEN_RST),
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .PAUSE_RST(PAUSE_RST)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .dpStat(statBus), .ctlOut(ctlBus),
    .macTxEn(macTxEn), .cfgPromisc(cfgPromisc), .cfgCrcAppend(cfgCrcAppend),
    .cfgTxPad(cfgTxPad), .cfgPauseQuanta(cfgPauseQuanta), .cfgLinkMode(cfgLinkMode),
    .softResetBusy(softResetBusy)
  );

  mac_ctl_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctlIn(ctlBus),
    .rxFrameStart(rxFrameStart), .rxFrameEnd(rxFrameEnd), .rxFrameLen(rxFrameLen),
    .txBusy(txBusy), .txFifoEmpty(txFifoEmpty),
    .dpStat(statBus), .rxFrameActive(rxFrameActive), .rxOversize(rxOversize)
  );

  assign macRxEn = ctlBus.rxEn;
endmodule

// File: rtl/mac_ctl_core_chk.sv
module mac_ctl_core_chk #(
  parameter int SWR_CYCLES = 16
) (
  input logic clk,
  input logic rstN,
  input logic softResetBusy,
  input logic macTxEn,
  input logic macRxEn,
  input logic rxFrameStart,
  input logic rxFrameEnd,
  input logic rxFrameActive,
  input logic rxOversize
);
  localparam int RUN_W = $clog2(SWR_CYCLES + 2) + 1;
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (softResetBusy) busyRun <= busyRun + RUN_W'(1);
    else busyRun <= '0;
  end

  p_swr_bounded_r3: assert property (@(posedge clk) disable iff (!rstN)
    softResetBusy |-> (busyRun < RUN_W'(SWR_CYCLES)));

  p_swr_gates_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    softResetBusy |-> (!macTxEn && !macRxEn));

  p_rise_needs_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFrameActive) |-> $past(rxFrameStart));

  p_oversize_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxOversize |=> !rxOversize);

  p_oversize_at_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxOversize |-> $past(rxFrameEnd));

  p_no_accept_disabled_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!macRxEn && !rxFrameActive) |=> !rxFrameActive);
endmodule

bind mac_ctl_core mac_ctl_core_chk #(.SWR_CYCLES(SWR_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .softResetBusy(softResetBusy),
  .macTxEn(macTxEn), .macRxEn(macRxEn),
  .rxFrameStart(rxFrameStart), .rxFrameEnd(rxFrameEnd),
  .rxFrameActive(rxFrameActive), .rxOversize(rxOversize)
);

// File: tb/mac_ctl_core_tb_top.sv
module mac_ctl_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rxFrameStart = 1'b0, rxFrameEnd = 1'b0;
  logic [15:0] rxFrameLen = '0;
  logic        txBusy = 1'b1, txFifoEmpty = 1'b0;
  logic        macTxEn, macRxEn, rxFrameActive, rxOversize, softResetBusy;
  logic        cfgPromisc, cfgCrcAppend, cfgTxPad;
  logic [15:0] cfgPauseQuanta, cfgLinkMode;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mac_ctl_core dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .rxFrameStart(rxFrameStart), .rxFrameEnd(rxFrameEnd), .rxFrameLen(rxFrameLen),
    .txBusy(txBusy), .txFifoEmpty(txFifoEmpty),
    .macTxEn(macTxEn), .macRxEn(macRxEn), .rxFrameActive(rxFrameActive),
    .rxOversize(rxOversize), .softResetBusy(softResetBusy),
    .cfgPromisc(cfgPromisc), .cfgCrcAppend(cfgCrcAppend), .cfgTxPad(cfgTxPad),
    .cfgPauseQuanta(cfgPauseQuanta), .cfgLinkMode(cfgLinkMode)
  );

  localparam logic [11:0] A_CMD = 12'h008, A_MAX = 12'h014, A_EVT = 12'h040,
                          A_PAU = 12'h054, A_LNK = 12'h300;

  function automatic bit lenAccepted(int unsigned v);
    return (v >= 64) && (v <= 32736);
  endfunction

  function automatic bit expectOver(int unsigned len, int unsigned lim, bit chkOn);
    return chkOn && (len > lim);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulseStart();
    rxFrameStart = 1'b1;
    @(negedge clk);
    rxFrameStart = 1'b0;
  endtask

  task automatic runFrame(input int unsigned len, input int unsigned lim, input bit chkOn);
    pulseStart();
    check("R4 frame accepted", {31'd0, rxFrameActive}, 32'd1);
    rxFrameEnd = 1'b1; rxFrameLen = 16'(len);
    @(negedge clk);
    rxFrameEnd = 1'b0;
    check($sformatf("R9 oversize len=%0d", len), {31'd0, rxOversize},
          {31'd0, expectOver(len, lim, chkOn)});
    @(negedge clk);
    check("R9 oversize single cycle", {31'd0, rxOversize}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned modelMax;
    int n;
    d = $urandom(32'h5EED);

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_CMD, d); check("R1 command reset", d, 32'h0);
    rd(A_MAX, d); check("R1 maxlen reset", d, 32'd1536);
    rd(A_PAU, d); check("R1 pause reset", d, 32'h0000_F000);
    rd(A_LNK, d); check("R1 link reset", d, 32'h0);
    rd(A_EVT, d); check("R1 events reset", d, 32'h0);

    // R2 command bits
    wr(A_CMD, 32'h0000_0853);
    rd(A_CMD, d); check("R2 command readback", d, 32'h0000_0853);
    check("R2 enables/config", {27'd0, macTxEn, macRxEn, cfgPromisc, cfgCrcAppend, cfgTxPad},
          32'h1F);
    wr(A_CMD, 32'hFFFF_EFFF);
    rd(A_CMD, d); check("R2 mask", d, 32'h2002_0853);
    wr(A_CMD, 32'h0000_0002);
    check("R2 rx only", {30'd0, macTxEn, macRxEn}, 32'h1);

    // R10 link mode
    wr(A_LNK, 32'hFFFF_FFFF);
    rd(A_LNK, d); check("R10 link mask", d, 32'h0000_F047);
    check("R10 link output", {16'd0, cfgLinkMode}, 32'h0000_F047);

    // R11 pause quanta, random values
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v;
      v = $urandom;
      wr(A_PAU, v);
      rd(A_PAU, d); check("R11 pause readback", d, {16'd0, v[15:0]});
      check("R11 pause output", {16'd0, cfgPauseQuanta}, {16'd0, v[15:0]});
    end

    // R8 max length, directed edges then random
    modelMax = 1536;
    foreach (d[i]) begin end
    for (int i = 0; i < 24; i++) begin
      int unsigned v;
      case (i)
        0: v = 63; 1: v = 64; 2: v = 32736; 3: v = 32737;
        default: v = $urandom_range(0, 40000);
      endcase
      wr(A_MAX, v);
      if (lenAccepted(v)) modelMax = v;
      rd(A_MAX, d); check($sformatf("R8 maxlen write %0d", v), d, modelMax);
    end

    // R9 oversize with limit 200
    wr(A_MAX, 32'd200);
    runFrame(200, 200, 1'b1);
    runFrame(201, 200, 1'b1);
    for (int i = 0; i < 10; i++) runFrame($urandom_range(150, 250), 200, 1'b1);
    wr(A_CMD, 32'h0002_0002);
    runFrame(1000, 200, 1'b0);

    // R12 start ignored while disabled
    wr(A_CMD, 32'h0);
    pulseStart();
    check("R12 no frame when disabled", {31'd0, rxFrameActive}, 32'd0);

    // R4 / R5 graceful stop
    wr(A_CMD, 32'h0000_0002);
    wr(A_EVT, 32'h0000_0060);
    rd(A_EVT, d); check("R7 clear events", d, 32'h0);
    pulseStart();
    wr(A_CMD, 32'h2000_0002);
    @(negedge clk);
    rd(A_EVT, d); check("R5 no idle while frame active", d & 32'h40, 32'h0);
    check("R4 active frame continues", {31'd0, rxFrameActive}, 32'd1);
    rxFrameEnd = 1'b1; rxFrameLen = 16'd100;
    @(negedge clk);
    rxFrameEnd = 1'b0;
    check("R4 frame ended", {31'd0, rxFrameActive}, 32'd0);
    @(negedge clk);
    rd(A_EVT, d); check("R5 rx idle set", d & 32'h40, 32'h40);
    pulseStart();
    check("R4 start ignored while stopped", {31'd0, rxFrameActive}, 32'd0);

    // R7 sticky, write 0 keeps, write 1 clears
    wr(A_CMD, 32'h0000_0002);
    wr(A_EVT, 32'h0);
    rd(A_EVT, d); check("R7 write zero keeps", d & 32'h40, 32'h40);
    wr(A_EVT, 32'h40);
    rd(A_EVT, d); check("R7 write one clears", d & 32'h40, 32'h0);

    // R6 transmit idle
    txBusy = 1'b0; txFifoEmpty = 1'b1;
    @(negedge clk);
    rd(A_EVT, d); check("R6 tx idle set", d & 32'h20, 32'h20);
    txBusy = 1'b1;
    wr(A_EVT, 32'h20);
    txBusy = 1'b0; txFifoEmpty = 1'b0;
    @(negedge clk);
    rd(A_EVT, d); check("R6 tx idle stays clear with fifo data", d & 32'h20, 32'h0);
    txBusy = 1'b1;

    // R3 soft reset
    wr(A_LNK, 32'h0000_D046);
    wr(A_PAU, 32'h0000_1234);
    wr(A_MAX, 32'd500);
    wr(A_CMD, 32'h0000_1853);
    check("R3 busy output", {31'd0, softResetBusy}, 32'd1);
    rd(A_CMD, d); check("R3 bit12 reads 1", d & 32'h1000, 32'h1000);
    check("R3 enables low", {30'd0, macTxEn, macRxEn}, 32'h0);
    wr(A_PAU, 32'h0000_4321);
    n = 0;
    while (softResetBusy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R3 remaining busy cycles", n, 32'd15);
    rd(A_CMD, d); check("R3 command cleared", d, 32'h0);
    rd(A_PAU, d); check("R3 pause restored", d, 32'h0000_F000);
    rd(A_MAX, d); check("R3 maxlen restored", d, 32'd1536);
    rd(A_LNK, d); check("R3 link kept", d, 32'h0000_D046);
    rd(A_EVT, d); check("R3 events cleared", d, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule